// File: doc/BRIEF.md
# Sequential Multiply and Divide Unit with High/Low Result Registers

This block multiplies and divides two integer operands one bit per clock and keeps its results in two result registers, `hi` and `lo`. A core pulses `start` with an operation code and two operands. The unit then raises `busy` for a fixed number of cycles and writes both result registers on the same clock edge that lowers `busy`. The core reads the registers directly from the `hi` and `lo` outputs whenever it chooses. The core must not read a result while `busy` is high, because the registers still hold the results of the previous operation during that time.

A multiplication produces a double-width product. The upper half goes to `hi` and the lower half goes to `lo`. A division places the remainder in `hi` and the quotient in `lo`. Signed operations work on the magnitudes of the operands and correct the signs at the end. Division by zero needs no special handling elsewhere in the core, because it finishes in the normal number of cycles and produces a defined pattern.

Top module: `mdu_top`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `busy` is 0 and both `hi` and `lo` are 0 until the first operation completes.
- R2: A `start` pulse sampled while idle raises `busy` on the next edge. `busy` then stays high for exactly W cycles. `hi` and `lo` take their new values on the edge where `busy` falls.
- R3: Operation code 2'b00 is a signed multiply. Both operands are taken as two's complement values. The 2W-bit product has its upper W bits in `hi` and its lower W bits in `lo`.
- R4: Operation code 2'b01 is an unsigned multiply with the same split of the product as R3.
- R5: Operation code 2'b10 is a signed divide. `lo` holds the quotient rounded toward zero. `hi` holds the remainder, which carries the sign of the dividend. The most negative value divided by -1 gives the most negative value in `lo` and 0 in `hi`.
- R6: Operation code 2'b11 is an unsigned divide, with the quotient in `lo` and the remainder in `hi`.
- R7: Any divide with a zero divisor completes in the normal number of cycles with all ones in `lo` and the unchanged dividend bits in `hi`.
- R8: `hi` and `lo` change only on the edge that ends an operation. While the unit is busy, and while it is idle, both keep their previous values.
- R9: A `start` pulse sampled while `busy` is high has no effect. The operation in flight keeps its operands, its length and its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Operation code (see R3 to R6) |
| opa | input | W | Multiplicand or dividend |
| opb | input | W | Multiplier or divisor |
| busy | output | 1 | An operation is in progress |
| hi | output | W | Upper product half or remainder |
| lo | output | W | Lower product half or quotient |

## Verification
The assertions check the following on every cycle:
- The exact number of cycles `busy` stays high.
- That an idle start always launches an operation.
- That a start during a run neither ends nor stretches it.
- That the result registers never move except on the edge where `busy` falls.
- The all-ones and dividend pattern written by a zero-divisor divide.

The arithmetic itself can be shown only by the bench. It sweeps every operand pair of a 4-bit configuration under all four operation codes and compares each result with products, quotients and remainders computed as integers. A subset of these runs has a conflicting start injected mid-operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [1:0] {
        MD_MUL_S = 2'b00,
        MD_MUL_U = 2'b01,
        MD_DIV_S = 2'b10,
        MD_DIV_U = 2'b11
    } md_op_e;

    function automatic logic md_is_div(input md_op_e o);
        return (o == MD_DIV_S) || (o == MD_DIV_U);
    endfunction

    function automatic logic md_is_signed(input md_op_e o);
        return (o == MD_MUL_S) || (o == MD_DIV_S);
    endfunction

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  md_op_e         op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   mag_a,
    output logic [W-1:0]   mag_b,
    output logic           neg_a,
    output logic           neg_b
);

    logic sgn;

    always_comb begin
        sgn   = md_is_signed(op);
        neg_a = sgn & opa[W-1];
        neg_b = sgn & opb[W-1];
        mag_a = neg_a ? W'(~opa + 1'b1) : opa;
        mag_b = neg_b ? W'(~opb + 1'b1) : opb;
    end

endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
    parameter int W = 32
) (
    input  logic           is_div,
    input  logic [2*W:0]   acc,
    input  logic [W-1:0]   opnd,
    output logic [2*W:0]   acc_nxt
);

    // Multiply: acc = {partial (W+1), multiplier bits (W)}, shift right.
    // Divide:   acc = {remainder (W+1), dividend/quotient (W)}, shift left.
    logic [W:0]   addend;
    logic [W:0]   sum;
    logic [W:0]   shifted;
    logic [W+1:0] diff;

    always_comb begin
        addend  = acc[0] ? {1'b0, opnd} : '0;
        sum     = acc[2*W:W] + addend;
        shifted = {acc[2*W-1:W], acc[W-1]};
        diff    = {1'b0, shifted} - {2'b00, opnd};
        if (is_div) begin
            if (!diff[W+1]) begin
                acc_nxt = {diff[W:0], acc[W-2:0], 1'b1};
            end else begin
                acc_nxt = {shifted, acc[W-2:0], 1'b0};
            end
        end else begin
            acc_nxt = {1'b0, sum, acc[W-1:1]};
        end
    end

endmodule

// File: rtl/mdu_result_fix.sv
module mdu_result_fix #(
    parameter int W = 32
) (
    input  logic           is_div,
    input  logic           neg_a,
    input  logic           neg_b,
    input  logic           div_zero,
    input  logic [W-1:0]   raw_a,
    input  logic [2*W:0]   acc,
    output logic [W-1:0]   res_hi,
    output logic [W-1:0]   res_lo
);

    logic [2*W-1:0] prod;
    logic [2*W-1:0] prod_f;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;
    logic           flip;

    always_comb begin
        flip   = neg_a ^ neg_b;
        prod   = acc[2*W-1:0];
        prod_f = flip ? (2*W)'(~prod + 1'b1) : prod;
        quo    = acc[W-1:0];
        rem    = acc[2*W-1:W];
        if (!is_div) begin
            res_hi = prod_f[2*W-1:W];
            res_lo = prod_f[W-1:0];
        end else if (div_zero) begin
            res_hi = raw_a;
            res_lo = '1;
        end else begin
            res_hi = neg_a ? W'(~rem + 1'b1) : rem;
            res_lo = flip  ? W'(~quo + 1'b1) : quo;
        end
    end

endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic           busy,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);

    localparam int          CW   = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          is_div;
        logic          neg_a;
        logic          neg_b;
        logic          dz;
        logic [W-1:0]  opnd;
        logic [W-1:0]  raw_a;
        logic [2*W:0]  acc;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } st_t;

    st_t st_d, st_q;

    md_op_e       op_e;
    logic [W-1:0] mag_a, mag_b;
    logic         in_neg_a, in_neg_b;
    logic [2*W:0] acc_nxt;
    logic [W-1:0] res_hi, res_lo;

    assign op_e = md_op_e'(op);

    mdu_operand_prep #(.W(W)) u_prep (
        .op    (op_e),
        .opa   (opa),
        .opb   (opb),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .neg_a (in_neg_a),
        .neg_b (in_neg_b)
    );

    mdu_step #(.W(W)) u_step (
        .is_div  (st_q.is_div),
        .acc     (st_q.acc),
        .opnd    (st_q.opnd),
        .acc_nxt (acc_nxt)
    );

    mdu_result_fix #(.W(W)) u_fix (
        .is_div   (st_q.is_div),
        .neg_a    (st_q.neg_a),
        .neg_b    (st_q.neg_b),
        .div_zero (st_q.dz),
        .raw_a    (st_q.raw_a),
        .acc      (acc_nxt),
        .res_hi   (res_hi),
        .res_lo   (res_lo)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.is_div = md_is_div(op_e);
                st_d.neg_a  = in_neg_a;
                st_d.neg_b  = in_neg_b;
                st_d.dz     = md_is_div(op_e) && (opb == '0);
                st_d.opnd   = mag_b;
                st_d.raw_a  = opa;
                st_d.acc    = {{(W+1){1'b0}}, mag_a};
            end
        end else begin
            st_d.acc = acc_nxt;
            st_d.cnt = CW'(st_q.cnt + 1'b1);
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.hi   = res_hi;
                st_d.lo   = res_lo;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign hi   = st_q.hi;
    assign lo   = st_q.lo;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         busy,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);

    localparam int BW = $clog2(W + 2) + 1;

    logic [BW-1:0] bcnt;
    logic          cap_dz;
    logic [W-1:0]  cap_a;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt   <= '0;
            cap_dz <= 1'b0;
            cap_a  <= '0;
        end else begin
            bcnt <= busy ? BW'(bcnt + 1'b1) : '0;
            if (start && !busy) begin
                cap_dz <= op[1] && (opb == '0);
                cap_a  <= opa;
            end
        end
    end

    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (int'(bcnt) == W));

    p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(hi) && $stable(lo)));

    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$fell(busy)) |-> ($stable(hi) && $stable(lo)));

    p_dz_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cap_dz) |-> ((lo == '1) && (hi == cap_a)));

    p_midstart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (int'(bcnt) < W - 1)) |=> busy);

endmodule

bind mdu_top mdu_checker #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .opa   (opa),
    .opb   (opb),
    .busy  (busy),
    .hi    (hi),
    .lo    (lo)
);

// File: tb/sim_mdu_top.sv
module sim_mdu_top;

    localparam int TW   = 4;
    localparam int MASK = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [1:0]    op;
    logic [TW-1:0] opa, opb;
    logic          busy;
    logic [TW-1:0] hi, lo;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mdu_top #(.W(TW)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .op    (op),
        .opa   (opa),
        .opb   (opb),
        .busy  (busy),
        .hi    (hi),
        .lo    (lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= (1 << (TW - 1))) ? v - (1 << TW) : v;
    endfunction

    task automatic expect_res(input int o, input int a, input int b,
                              output int eh, output int el);
        int p, q, r;
        case (o)
            0: begin p = sx(a) * sx(b); el = p & MASK; eh = (p >>> TW) & MASK; end
            1: begin p = a * b;         el = p & MASK; eh = (p >>> TW) & MASK; end
            2: begin
                if (b == 0) begin el = MASK; eh = a; end
                else begin q = sx(a) / sx(b); r = sx(a) % sx(b); el = q & MASK; eh = r & MASK; end
            end
            default: begin
                if (b == 0) begin el = MASK; eh = a; end
                else begin el = a / b; eh = a % b; end
            end
        endcase
    endtask

    task automatic run(input int o, input int a, input int b, input bit inject);
        int ph, pl, eh, el;
        string tag;
        ph = int'(hi);
        pl = int'(lo);
        if (b == 0 && o >= 2)  tag = "R7 zero divisor";
        else if (o == 0)       tag = "R3 signed mul";
        else if (o == 1)       tag = "R4 unsigned mul";
        else if (o == 2)       tag = "R5 signed div";
        else                   tag = "R6 unsigned div";
        if (inject) tag = {tag, " R9 mid start"};
        expect_res(o, a, b, eh, el);
        start = 1'b1;
        op    = 2'(o);
        opa   = TW'(a);
        opb   = TW'(b);
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        chk("R8 hi held while busy", int'(hi), ph);
        chk("R8 lo held while busy", int'(lo), pl);
        for (int c = 1; c < TW; c++) begin
            if (inject && c == 1) begin
                start = 1'b1;
                op    = 2'(~o);
                opa   = TW'(~a);
                opb   = TW'(b + 1);
            end
            @(negedge clk);
            start = 1'b0;
            chk(inject ? "R9 busy kept" : "R2 busy kept", int'(busy), 1);
            chk("R8 hi held while busy", int'(hi), ph);
        end
        @(negedge clk);
        chk("R2 busy ends after W cycles", int'(busy), 0);
        chk({tag, " hi"}, int'(hi), eh);
        chk({tag, " lo"}, int'(lo), el);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R2 actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        op    = '0;
        opa   = '0;
        opb   = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 hi after reset", int'(hi), 0);
        chk("R1 lo after reset", int'(lo), 0);

        for (int o = 0; o < 4; o++) begin
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    run(o, a, b, ((a + b) % 5) == 0);
                end
            end
        end

        // Idle: results must not move with inputs toggling and no start
        begin
            int ph, pl;
            ph  = int'(hi);
            pl  = int'(lo);
            opa = ~opa;
            opb = ~opb;
            op  = 2'b01;
            repeat (3) @(negedge clk);
            chk("R8 hi stable when idle", int'(hi), ph);
            chk("R8 lo stable when idle", int'(lo), pl);
            chk("R2 no start stays idle", int'(busy), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule